// File: doc/BRIEF.md
# Multicart address-latched bank mapper

This block switches program-ROM banks and the nametable mirroring for a multi-game cartridge on an 8-bit console. The CPU selects a game by writing anywhere in the upper half of its address space. The block keeps the address of that write and discards the data. Fourteen address bits are held. From them the block derives a seven-bit bank number, a choice between one 32 KB page and one mirrored 16 KB page, an open-bus flag and a mirroring mode.

On every CPU access the block maps the CPU address through the held state to a physical ROM byte address. It tells the ROM whether to drive the bus, and it returns either the ROM byte or the idle value 0xFF. On the video side it turns the two PPU nametable address lines into the single line that goes to the console's nametable RAM. The parameter `ROM_MB` (1 to 4, in megabytes) selects how the two outer bank bits are decoded. Any other value is decoded like 4. The block has no data stream, so all of its pins are plain control and address lines with no valid/ready handshake. The ROM path is combinational from the held state and the live CPU address. A write changes the outputs in the clock cycle after the edge that captures it.

Top module: `mcart_addr_mapper`

## Requirements
- R1: On a rising clock edge with `cpu_wr`=1 and `cpu_addr[15]`=1, the block holds `cpu_addr[13:0]`. A write with `cpu_addr[15]`=0 leaves every output mapping unchanged. The block has no write-data input.
- R2: The raw bank number is {held[9:8], held[4:0]}, with held[9:8] as bank bits 6:5. It appears on `rom_addr[21:15]`.
- R3: When held bit 11 is 0, `rom_addr` = bank × 32768 + `cpu_addr[14:0]`.
- R4: When held bit 11 is 1, `rom_addr[14]` is held bit 12 for both CPU halves 0x8000 and 0xC000. The other address bits follow R3.
- R5: With ROM_MB=1, an outer field held[9:8] of 1, 2 or 3 selects open bus.
- R6: With ROM_MB=2, outer field 1 or 3 selects open bus. Outer field 2 uses bank bits 6:5 = 01.
- R7: With ROM_MB=3, outer field 1 selects open bus. Outer field 2 gives bank bits 6:5 = 01, and outer field 3 gives 10.
- R8: With ROM_MB=4, the bank number is used unmodified and open bus never occurs.
- R9: In open bus, `rom_en`=0 and `cpu_rdata`=0xFF. Otherwise `rom_en`=`cpu_addr[15]` and `cpu_rdata`=`rom_rdata`.
- R10: `nt_a10` is 0 when held bit 10 is 1. Otherwise it is `ppu_a11` when held bit 13 is 1, and `ppu_a10` when held bit 13 is 0.
- R11: After reset the held value is 0. This gives bank 0, 32 KB mode, no open bus and `nt_a10`=`ppu_a10`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising edge |
| rom_rdata | input | 8 | Byte read from ROM |
| ppu_a10 | input | 1 | PPU nametable address bit 10 |
| ppu_a11 | input | 1 | PPU nametable address bit 11 |
| rom_addr | output | 22 | Physical ROM byte address |
| rom_en | output | 1 | ROM drives the CPU bus |
| cpu_rdata | output | 8 | Byte returned to the CPU |
| nt_a10 | output | 1 | Nametable RAM address bit 10 |

## Verification
The assertions assume that `cpu_wr` and `cpu_addr` are steady around each rising edge and that a strobe is meant as one write per cycle in which it is high. They also assume no input is unknown once reset has been released. The stimulus changes every input only at the falling edge. It holds `cpu_wr` high for exactly one cycle per write and samples outputs a short time after the falling edge. The random addresses cover the full 16-bit range, including writes below the program window that must be ignored.

// File: rtl/mcart_pkg.sv
package mcart_pkg;
  localparam int HOLD_W  = 14;
  localparam int BANK_W  = 7;
  localparam int OFF_W   = 15;
  localparam int ROM_AW  = BANK_W + OFF_W;
  localparam int DATA_W  = 8;
  localparam int CPU_AW  = 16;

  localparam int B_OUTER_LO = 8;
  localparam int B_ONESCR   = 10;
  localparam int B_MODE16   = 11;
  localparam int B_HALF     = 12;
  localparam int B_HORZ     = 13;

  localparam logic [DATA_W-1:0] IDLE_BYTE = '1;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2
  } mir_t;
endpackage

// File: rtl/mcart_hold_reg.sv
module mcart_hold_reg
  import mcart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic [HOLD_W-1:0] held
);
  logic hit;

  assign hit = cpu_wr & cpu_addr[CPU_AW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else if (hit) begin
      held <= cpu_addr[HOLD_W-1:0];
    end
  end
endmodule

// File: rtl/mcart_bank_dec.sv
module mcart_bank_dec
  import mcart_pkg::*;
#(
  parameter int ROM_MB = 2
) (
  input  logic [HOLD_W-1:0] held,
  output logic [BANK_W-1:0] bank,
  output logic              mode16,
  output logic              half,
  output logic              open_bus
);
  localparam int INNER_W = BANK_W - 2;

  logic [1:0]         outer;
  logic [INNER_W-1:0] inner;

  assign outer  = held[B_OUTER_LO +: 2];
  assign inner  = held[INNER_W-1:0];
  assign mode16 = held[B_MODE16];
  assign half   = held[B_HALF];

  generate
    if (ROM_MB == 1) begin : g_1m
      always_comb begin
        bank     = {outer, inner};
        open_bus = (outer != 2'd0);
      end
    end else if (ROM_MB == 2) begin : g_2m
      always_comb begin
        bank     = {outer, inner};
        open_bus = outer[0];
        if (outer == 2'd2) bank[BANK_W-1 -: 2] = 2'b01;
      end
    end else if (ROM_MB == 3) begin : g_3m
      always_comb begin
        bank     = {outer, inner};
        open_bus = (outer == 2'd1);
        if (outer == 2'd2) bank[BANK_W-1 -: 2] = 2'b01;
        if (outer == 2'd3) bank[BANK_W-1 -: 2] = 2'b10;
      end
    end else begin : g_full
      always_comb begin
        bank     = {outer, inner};
        open_bus = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/mcart_prg_map.sv
module mcart_prg_map
  import mcart_pkg::*;
(
  input  logic [BANK_W-1:0] bank,
  input  logic              mode16,
  input  logic              half,
  input  logic              open_bus,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_en,
  output logic [DATA_W-1:0] cpu_rdata
);
  logic page_bit;

  always_comb begin
    page_bit  = mode16 ? half : cpu_addr[OFF_W-1];
    rom_addr  = {bank, page_bit, cpu_addr[OFF_W-2:0]};
    rom_en    = cpu_addr[CPU_AW-1] & ~open_bus;
    cpu_rdata = open_bus ? IDLE_BYTE : rom_rdata;
  end
endmodule

// File: rtl/mcart_nt_mirror.sv
module mcart_nt_mirror
  import mcart_pkg::*;
(
  input  logic [HOLD_W-1:0] held,
  input  logic              ppu_a10,
  input  logic              ppu_a11,
  output mir_t              mode,
  output logic              nt_a10
);
  always_comb begin
    if (held[B_ONESCR])    mode = MIR_ONE_LO;
    else if (held[B_HORZ]) mode = MIR_HORZ;
    else                   mode = MIR_VERT;
  end

  always_comb begin
    unique case (mode)
      MIR_HORZ:   nt_a10 = ppu_a11;
      MIR_ONE_LO: nt_a10 = 1'b0;
      default:    nt_a10 = ppu_a10;
    endcase
  end
endmodule

// File: rtl/mcart_addr_mapper.sv
module mcart_addr_mapper
  import mcart_pkg::*;
#(
  parameter int ROM_MB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic              ppu_a10,
  input  logic              ppu_a11,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_en,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              nt_a10
);
  logic [HOLD_W-1:0] held;
  logic [BANK_W-1:0] bank_num;
  logic              mode16;
  logic              half;
  logic              open_bus;
  mir_t              mir_mode;

  mcart_hold_reg u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .held     (held)
  );

  mcart_bank_dec #(.ROM_MB(ROM_MB)) u_dec (
    .held     (held),
    .bank     (bank_num),
    .mode16   (mode16),
    .half     (half),
    .open_bus (open_bus)
  );

  mcart_prg_map u_prg (
    .bank      (bank_num),
    .mode16    (mode16),
    .half      (half),
    .open_bus  (open_bus),
    .cpu_addr  (cpu_addr),
    .rom_rdata (rom_rdata),
    .rom_addr  (rom_addr),
    .rom_en    (rom_en),
    .cpu_rdata (cpu_rdata)
  );

  mcart_nt_mirror u_nt (
    .held    (held),
    .ppu_a10 (ppu_a10),
    .ppu_a11 (ppu_a11),
    .mode    (mir_mode),
    .nt_a10  (nt_a10)
  );
endmodule

// File: rtl/mcart_mapper_chk.sv
module mcart_mapper_chk
  import mcart_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic              ppu_a10,
  input logic              ppu_a11,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_en,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              nt_a10,
  input logic [BANK_W-1:0] bank_num,
  input logic              mode16,
  input logic              open_bus
);
  logic win_wr;
  assign win_wr = cpu_wr & cpu_addr[CPU_AW-1];

  p_hold_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !win_wr |=> ($stable(bank_num) && $stable(mode16) && $stable(open_bus)));

  p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(win_wr) && !$past(cpu_addr[B_MODE16])
    |-> rom_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);

  p_half_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(win_wr) && $past(cpu_addr[B_MODE16])
    |-> rom_addr[OFF_W-1] == $past(cpu_addr[B_HALF]));

  p_idle_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[CPU_AW-1] && !rom_en |-> cpu_rdata == IDLE_BYTE);

  p_one_screen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(win_wr) && $past(cpu_addr[B_ONESCR]) |-> !nt_a10);

  p_horz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(win_wr) && !$past(cpu_addr[B_ONESCR]) && $past(cpu_addr[B_HORZ])
    |-> nt_a10 == ppu_a11);

  p_vert_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(win_wr) && !$past(cpu_addr[B_ONESCR]) && !$past(cpu_addr[B_HORZ])
    |-> nt_a10 == ppu_a10);
endmodule

bind mcart_addr_mapper mcart_mapper_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_wr    (cpu_wr),
  .ppu_a10   (ppu_a10),
  .ppu_a11   (ppu_a11),
  .rom_addr  (rom_addr),
  .rom_en    (rom_en),
  .cpu_rdata (cpu_rdata),
  .nt_a10    (nt_a10),
  .bank_num  (bank_num),
  .mode16    (mode16),
  .open_bus  (open_bus)
);

// File: tb/mcart_addr_mapper_tb.sv
`timescale 1ns/1ps
module mcart_addr_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  rom_rdata = 8'h0;
  logic        ppu_a10 = 1'b0;
  logic        ppu_a11 = 1'b0;

  logic [21:0] ra  [4];
  logic        ren [4];
  logic [7:0]  rd  [4];
  logic        nt  [4];

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [13:0] model = '0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < 4; g++) begin : g_sz
    mcart_addr_mapper #(.ROM_MB(g + 1)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_addr  (cpu_addr),
      .cpu_wr    (cpu_wr),
      .rom_rdata (rom_rdata),
      .ppu_a10   (ppu_a10),
      .ppu_a11   (ppu_a11),
      .rom_addr  (ra[g]),
      .rom_en    (ren[g]),
      .cpu_rdata (rd[g]),
      .nt_a10    (nt[g])
    );
  end

  function automatic bit exp_open(int mb, logic [13:0] h);
    logic [1:0] o = h[9:8];
    case (mb)
      1: return o != 2'd0;
      2: return o[0];
      3: return o == 2'd1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [6:0] exp_bank(int mb, logic [13:0] h);
    logic [6:0] b = {h[9:8], h[4:0]};
    if ((mb == 2 || mb == 3) && h[9:8] == 2'd2) b[6:5] = 2'b01;
    if (mb == 3 && h[9:8] == 2'd3) b[6:5] = 2'b10;
    return b;
  endfunction

  task automatic chk(bit ok, string tag, string what, int mb, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s size=%0dMB act=%h exp=%h", tag, what, mb, act, exp);
    end
  endtask

  task automatic do_write(logic [15:0] a);
    @(negedge clk);
    cpu_addr = a;
    cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    if (a[15]) model = a[13:0];
  endtask

  task automatic probe(logic [15:0] a, logic p10, logic p11, logic [7:0] d, string extra);
    @(negedge clk);
    cpu_addr = a;
    ppu_a10 = p10;
    ppu_a11 = p11;
    rom_rdata = d;
    cpu_wr = 1'b0;
    #1;
    for (int s = 0; s < 4; s++) begin
      int mb = s + 1;
      bit eo = exp_open(mb, model);
      logic [6:0] eb = exp_bank(mb, model);
      logic [21:0] ea = {eb, model[11] ? model[12] : a[14], a[13:0]};
      logic en_e = a[15] & ~eo;
      logic [7:0] ed = eo ? 8'hFF : d;
      logic ent = model[10] ? 1'b0 : (model[13] ? p11 : p10);
      string st;
      case (mb)
        1: st = "R5";
        2: st = "R6";
        3: st = "R7";
        default: st = "R8";
      endcase
      if (extra != "") st = extra;
      chk(ren[s] == en_e, st, "rom_en", mb, 32'(ren[s]), 32'(en_e));
      chk(rd[s] == ed, (extra != "") ? extra : "R9", "cpu_rdata", mb, 32'(rd[s]), 32'(ed));
      chk(nt[s] == ent, (extra != "") ? extra : "R10", "nt_a10", mb, 32'(nt[s]), 32'(ent));
      if (!eo) begin
        chk(ra[s][21:15] == eb, (extra != "") ? extra : ((mb == 4) ? "R2" : st), "bank", mb,
            32'(ra[s][21:15]), 32'(eb));
        chk(ra[s] == ea, (extra != "") ? extra : (model[11] ? "R4" : "R3"), "rom_addr", mb,
            32'(ra[s]), 32'(ea));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model = '0;
    // R11: reset state seen at the ports
    probe(16'h8123, 1'b1, 1'b0, 8'h5A, "R11");
    probe(16'hC456, 1'b0, 1'b1, 8'hA5, "R11");

    // outer field decode per ROM size, R5 R6 R7 R8 R2
    for (int o = 0; o < 4; o++) begin
      do_write(16'h8000 | 16'(o << 8) | 16'h0013);
      probe(16'h8ABC, 1'b1, 1'b0, 8'h3C, "");
      probe(16'hF001, 1'b0, 1'b1, 8'hC3, "");
    end

    // R4: 16 KB mode, both halves of the window, upper and lower half selected
    do_write(16'h9805);
    probe(16'h8123, 1'b0, 1'b0, 8'h11, "");
    probe(16'hC123, 1'b0, 1'b0, 8'h22, "");
    do_write(16'h8805);
    probe(16'h8123, 1'b0, 1'b0, 8'h33, "");
    probe(16'hC123, 1'b0, 1'b0, 8'h44, "");

    // R10: mirroring priority
    do_write(16'hA400);
    probe(16'h8000, 1'b1, 1'b1, 8'h00, "");
    do_write(16'hA000);
    probe(16'h8000, 1'b1, 1'b0, 8'h00, "");
    probe(16'h8000, 1'b0, 1'b1, 8'h00, "");
    do_write(16'h8000);
    probe(16'h8000, 1'b1, 1'b0, 8'h00, "");
    probe(16'h8000, 1'b0, 1'b1, 8'h00, "");

    // R1: write below the window is ignored
    do_write(16'hB917);
    do_write(16'h7FFF);
    probe(16'hC777, 1'b1, 1'b0, 8'h99, "R1");
    do_write(16'h2400);
    probe(16'h8777, 1'b1, 1'b1, 8'h98, "R1");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a = 16'($urandom);
      if ($urandom % 8 == 0) a[15] = 1'b0;
      do_write(a);
      for (int k = 0; k < 2; k++) begin
        logic [15:0] p = 16'($urandom);
        if ($urandom % 6 != 0) p[15] = 1'b1;
        probe(p, 1'($urandom), 1'($urandom), 8'($urandom), "");
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule